// File: doc/BRIEF.md
# Serial Receiver Wake-Up Controller

This block sits next to an asynchronous serial receiver and keeps it asleep on request. The host sets a sleep request to start sleep. While the receiver sleeps, characters that the receiver finishes are not passed on: the controller holds back their data-valid strobe, so the host does not see traffic meant for other stations.

Sleep ends by one of two rules, chosen by a method-select input. In line-quiet mode, the controller counts bit-time ticks while the receive line stays high. It wakes once that count covers a whole frame. A frame is 10 bit times in the short word format and 11 in the long one. In address-tag mode, each finished character is tested on its top data bit. A character with that bit set is an address. The controller wakes on it and delivers that character to the host. Quiet gaps on the line play no part in address-tag mode.

Baud timing, bit sampling and transmission stay in the receiver. This block only sees a bit-time tick, the raw line level, and a character-done strobe with the received word.

Top module: `rxwake_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the sleeping flag to 0 and the quiet-line count to 0.
- R2: A cycle with `sleep_req_i` high makes `sleeping_o` read 1 after the next clock edge. This request wins over any wake condition in the same cycle.
- R3: In line-quiet mode (`wake_sel_i`=0) with the short format (`long_fmt_i`=0), `sleeping_o` drops at the clock edge that takes the 10th consecutive tick with the line high. Before that edge it stays 1.
- R4: In line-quiet mode with the long format (`long_fmt_i`=1), the wake needs the 11th consecutive high tick.
- R5: Any cycle with `rx_line_i` low resets the quiet count to zero. After such a cycle a full frame of high ticks is needed again.
- R6: In address-tag mode (`wake_sel_i`=1), a finished character whose top data bit is 1 clears `sleeping_o` at the next edge. Its `char_valid_o` is asserted in the same cycle as `char_done_i`. The top data bit is bit 7 in the short format and bit 8 in the long format.
- R7: In address-tag mode, characters whose top bit is 0 neither wake the receiver nor reach `char_valid_o`. A quiet line, however long, does not wake it.
- R8: While sleeping in line-quiet mode, `char_valid_o` stays 0. While awake, `char_valid_o` follows `char_done_i` in the same cycle.
- R9: A sleep request restarts the quiet count, so ticks seen before it do not count toward the wake threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req_i | input | 1 | Host request to enter sleep (one cycle) |
| wake_sel_i | input | 1 | Wake rule: 0 line-quiet, 1 address-tag |
| long_fmt_i | input | 1 | Word format: 0 short (8 data bits), 1 long (9 data bits) |
| bit_tick_i | input | 1 | One-cycle pulse per bit time |
| rx_line_i | input | 1 | Raw receive line level |
| char_done_i | input | 1 | Receiver finished a character |
| char_data_i | input | DATA_W | Received data word, LSB aligned |
| sleeping_o | output | 1 | Receiver is asleep |
| char_valid_o | output | 1 | Gated character-valid strobe to the host |

## Verification
The bench builds the block with its default `DATA_W` of 9. That value gives the long format its 11-bit-time frame and its top bit at position 8, while the short format keeps bit 7. Address tests can therefore set bit 8 alone, or bit 7 alone, and show that only the bit matching the current format wakes the receiver. With the default width the count saturates at 11. A random phase can then switch between formats and rules mid-sleep, which reaches counts at or past the short threshold.

// File: rtl/rxwake_pkg.sv
package rxwake_pkg;

  typedef enum logic {
    ST_AWAKE  = 1'b0,
    ST_ASLEEP = 1'b1
  } sleep_st_e;

  // Bit times in one frame: start + data + stop.
  function automatic int unsigned frame_bits(input logic long_fmt, input int unsigned data_w);
    return long_fmt ? (data_w + 2) : (data_w + 1);
  endfunction

  // Index of the address-tag bit for the selected format.
  function automatic int unsigned tag_index(input logic long_fmt, input int unsigned data_w);
    return long_fmt ? (data_w - 1) : (data_w - 2);
  endfunction

endpackage

// File: rtl/rxwake_idle_timer.sv
module rxwake_idle_timer
  import rxwake_pkg::*;
#(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             long_fmt,
  input  logic             tick,
  input  logic             line,
  output logic [CNT_W-1:0] quiet_cnt,
  output logic             quiet_hit
);

  localparam int unsigned LIM_S = frame_bits(1'b0, DATA_W);
  localparam int unsigned LIM_L = frame_bits(1'b1, DATA_W);
  localparam logic [CNT_W:0] LIM_S_V = (CNT_W+1)'(LIM_S);
  localparam logic [CNT_W:0] LIM_L_V = (CNT_W+1)'(LIM_L);
  localparam logic [CNT_W-1:0] CAP_V = CNT_W'(LIM_L);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W:0]   limit;

  assign limit   = long_fmt ? LIM_L_V : LIM_S_V;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (!line) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q < CAP_V)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign quiet_cnt = cnt_q;
  assign quiet_hit = line && tick && !restart && (cnt_inc >= limit);

endmodule

// File: rtl/rxwake_addr_detect.sv
module rxwake_addr_detect
  import rxwake_pkg::*;
#(
  parameter int unsigned DATA_W = 9
) (
  input  logic              char_done,
  input  logic [DATA_W-1:0] char_data,
  input  logic              long_fmt,
  output logic              tag_seen
);

  localparam int unsigned IDX_S = tag_index(1'b0, DATA_W);
  localparam int unsigned IDX_L = tag_index(1'b1, DATA_W);

  logic tag_bit;

  assign tag_bit  = long_fmt ? char_data[IDX_L] : char_data[IDX_S];
  assign tag_seen = char_done && tag_bit;

endmodule

// File: rtl/rxwake_sleep_state.sv
module rxwake_sleep_state
  import rxwake_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sleep_req,
  input  logic tag_mode,
  input  logic quiet_hit,
  input  logic tag_seen,
  input  logic char_done,
  output logic asleep,
  output logic wake_quiet,
  output logic wake_tag,
  output logic deliver
);

  sleep_st_e st_q, st_d;

  assign asleep     = (st_q == ST_ASLEEP);
  assign wake_quiet = asleep && !tag_mode && quiet_hit;
  assign wake_tag   = asleep && tag_mode && tag_seen;

  always_comb begin
    st_d = st_q;
    if (sleep_req) begin
      st_d = ST_ASLEEP;
    end else if (wake_quiet || wake_tag) begin
      st_d = ST_AWAKE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_AWAKE;
    end else begin
      st_q <= st_d;
    end
  end

  assign deliver = char_done && (!asleep || wake_tag);

endmodule

// File: rtl/rxwake_ctrl.sv
module rxwake_ctrl
  import rxwake_pkg::*;
#(
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_req_i,
  input  logic              wake_sel_i,
  input  logic              long_fmt_i,
  input  logic              bit_tick_i,
  input  logic              rx_line_i,
  input  logic              char_done_i,
  input  logic [DATA_W-1:0] char_data_i,
  output logic              sleeping_o,
  output logic              char_valid_o
);

  localparam int unsigned CNT_W = $clog2(frame_bits(1'b1, DATA_W) + 1);

  logic [CNT_W-1:0] quiet_cnt;
  logic             quiet_hit;
  logic             tag_seen;
  logic             wake_quiet;
  logic             wake_tag;

  rxwake_idle_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .restart   (sleep_req_i),
    .long_fmt  (long_fmt_i),
    .tick      (bit_tick_i),
    .line      (rx_line_i),
    .quiet_cnt (quiet_cnt),
    .quiet_hit (quiet_hit)
  );

  rxwake_addr_detect #(.DATA_W(DATA_W)) u_tag (
    .char_done (char_done_i),
    .char_data (char_data_i),
    .long_fmt  (long_fmt_i),
    .tag_seen  (tag_seen)
  );

  rxwake_sleep_state u_state (
    .clk        (clk),
    .rst        (rst),
    .sleep_req  (sleep_req_i),
    .tag_mode   (wake_sel_i),
    .quiet_hit  (quiet_hit),
    .tag_seen   (tag_seen),
    .char_done  (char_done_i),
    .asleep     (sleeping_o),
    .wake_quiet (wake_quiet),
    .wake_tag   (wake_tag),
    .deliver    (char_valid_o)
  );

endmodule

// File: rtl/rxwake_ctrl_chk.sv
module rxwake_ctrl_chk #(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sleep_req_i,
  input logic              wake_sel_i,
  input logic              long_fmt_i,
  input logic              rx_line_i,
  input logic              char_done_i,
  input logic [DATA_W-1:0] char_data_i,
  input logic              sleeping_o,
  input logic              char_valid_o,
  input logic [CNT_W-1:0]  quiet_cnt,
  input logic              wake_tag
);

  logic tag_bit;
  assign tag_bit = long_fmt_i ? char_data_i[DATA_W-1] : char_data_i[DATA_W-2];

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (!sleeping_o && quiet_cnt == '0));

  p_sleep_enter_r2: assert property (@(posedge clk) disable iff (rst)
    sleep_req_i |=> sleeping_o);

  p_cnt_cap_r4: assert property (@(posedge clk) disable iff (rst)
    quiet_cnt <= CNT_W'(DATA_W + 2));

  p_low_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (sleeping_o && !wake_sel_i && !rx_line_i) |=> sleeping_o);

  p_low_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (!rx_line_i) |=> (quiet_cnt == '0));

  p_tag_wake_r6: assert property (@(posedge clk) disable iff (rst)
    (sleeping_o && wake_sel_i && char_done_i && tag_bit && !sleep_req_i) |=> !sleeping_o);

  p_tag_deliver_r6: assert property (@(posedge clk) disable iff (rst)
    wake_tag |-> char_valid_o);

  p_data_blocked_r7: assert property (@(posedge clk) disable iff (rst)
    (sleeping_o && wake_sel_i && !tag_bit) |-> !char_valid_o);

  p_no_quiet_wake_r7: assert property (@(posedge clk) disable iff (rst)
    (sleeping_o && wake_sel_i && !char_done_i) |=> sleeping_o);

  p_blocked_r8: assert property (@(posedge clk) disable iff (rst)
    (sleeping_o && !wake_sel_i) |-> !char_valid_o);

  p_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (!sleeping_o && char_done_i) |-> char_valid_o);

  p_valid_src_r8: assert property (@(posedge clk) disable iff (rst)
    char_valid_o |-> char_done_i);

  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    sleep_req_i |=> (quiet_cnt == '0));

endmodule

bind rxwake_ctrl rxwake_ctrl_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sleep_req_i  (sleep_req_i),
  .wake_sel_i   (wake_sel_i),
  .long_fmt_i   (long_fmt_i),
  .rx_line_i    (rx_line_i),
  .char_done_i  (char_done_i),
  .char_data_i  (char_data_i),
  .sleeping_o   (sleeping_o),
  .char_valid_o (char_valid_o),
  .quiet_cnt    (quiet_cnt),
  .wake_tag     (wake_tag)
);

// File: tb/rxwake_ctrl_test.sv
module rxwake_ctrl_test;

  localparam int DW = 9;

  logic clk = 1'b0;
  logic rst, sleep_req, wsel, lfmt, tick, line, cdone;
  logic [DW-1:0] cdata;
  logic sleeping, cvalid;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  // reference state
  bit m_sleep;
  int m_cnt;

  always #4 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  rxwake_ctrl #(.DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .sleep_req_i(sleep_req), .wake_sel_i(wsel),
    .long_fmt_i(lfmt), .bit_tick_i(tick), .rx_line_i(line),
    .char_done_i(cdone), .char_data_i(cdata),
    .sleeping_o(sleeping), .char_valid_o(cvalid)
  );

  function automatic int thr_of(bit lf);
    return lf ? 11 : 10;
  endfunction

  function automatic bit tag_of(logic [DW-1:0] d, bit lf);
    return ((d >> (lf ? 8 : 7)) & 1) == 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  // One cycle: drive at negedge, check strobe, advance model, check flag.
  task automatic step(input string tag, input bit ss, input bit ws, input bit lf,
                      input bit tk, input bit ln, input bit cd, input logic [DW-1:0] d);
    bit wq, wt, nxt;
    int ncnt;
    @(negedge clk);
    sleep_req = ss; wsel = ws; lfmt = lf; tick = tk; line = ln; cdone = cd; cdata = d;
    #1;
    wq = m_sleep && !ws && ln && tk && !ss && (m_cnt + 1 >= thr_of(lf));
    wt = m_sleep && ws && cd && tag_of(d, lf);
    chk({tag, " valid"}, int'(cvalid), int'(cd && (!m_sleep || wt)));
    if (ss) ncnt = 0;
    else if (!ln) ncnt = 0;
    else if (tk && m_cnt < 11) ncnt = m_cnt + 1;
    else ncnt = m_cnt;
    nxt = ss ? 1'b1 : ((wq || wt) ? 1'b0 : m_sleep);
    @(posedge clk);
    m_sleep = nxt; m_cnt = ncnt;
    #1;
    chk({tag, " sleep"}, int'(sleeping), int'(m_sleep));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sleep_req = 0; wsel = 0; lfmt = 0; tick = 0; line = 1; cdone = 0; cdata = '0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    m_sleep = 0; m_cnt = 0;
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    bit ws, lf;
    void'($urandom(32'd2024));
    rst = 1'b1;
    do_reset();
    chk("R1 reset sleep", int'(sleeping), 0);

    // R2 + R3: short format line-quiet wake after 10 ticks
    step("R2 enter", 1, 0, 0, 0, 1, 0, '0);
    chk("R2 asleep", int'(sleeping), 1);
    for (int i = 0; i < 9; i++) step("R3 count", 0, 0, 0, 1, 1, 0, '0);
    chk("R3 still asleep at 9", int'(sleeping), 1);
    step("R3 char blocked R8", 0, 0, 0, 0, 1, 1, 9'h0FF);
    step("R3 tenth", 0, 0, 0, 1, 1, 0, '0);
    chk("R3 awake at 10", int'(sleeping), 0);
    step("R8 pass awake", 0, 0, 0, 0, 1, 1, 9'h012);

    // R4: long format needs 11
    step("R4 enter", 1, 0, 1, 0, 1, 0, '0);
    for (int i = 0; i < 10; i++) step("R4 count", 0, 0, 1, 1, 1, 0, '0);
    chk("R4 asleep at 10", int'(sleeping), 1);
    step("R4 eleventh", 0, 0, 1, 1, 1, 0, '0);
    chk("R4 awake at 11", int'(sleeping), 0);

    // R5: a low cycle restarts the count
    step("R5 enter", 1, 0, 0, 0, 1, 0, '0);
    for (int i = 0; i < 7; i++) step("R5 pre", 0, 0, 0, 1, 1, 0, '0);
    step("R5 low", 0, 0, 0, 0, 0, 0, '0);
    for (int i = 0; i < 9; i++) step("R5 post", 0, 0, 0, 1, 1, 0, '0);
    chk("R5 asleep after 9 post-low", int'(sleeping), 1);
    step("R5 tenth", 0, 0, 0, 1, 1, 0, '0);
    chk("R5 awake", int'(sleeping), 0);

    // R9: repeated sleep request restarts the count
    step("R9 enter", 1, 0, 0, 0, 1, 0, '0);
    for (int i = 0; i < 8; i++) step("R9 pre", 0, 0, 0, 1, 1, 0, '0);
    step("R9 re-request", 1, 0, 0, 1, 1, 0, '0);
    for (int i = 0; i < 9; i++) step("R9 post", 0, 0, 0, 1, 1, 0, '0);
    chk("R9 asleep after 9", int'(sleeping), 1);
    step("R9 tenth", 0, 0, 0, 1, 1, 0, '0);
    chk("R9 awake", int'(sleeping), 0);

    // R7: address mode, quiet line and data chars do not wake
    step("R7 enter", 1, 1, 0, 0, 1, 0, '0);
    for (int i = 0; i < 20; i++) step("R7 quiet", 0, 1, 0, 1, 1, 0, '0);
    chk("R7 quiet no wake", int'(sleeping), 1);
    step("R7 data char", 0, 1, 0, 0, 1, 1, 9'h07F);
    chk("R7 data no wake", int'(sleeping), 1);
    // long format: bit 7 alone is data
    step("R7 long bit7", 0, 1, 1, 0, 1, 1, 9'h080);
    chk("R7 long bit7 no wake", int'(sleeping), 1);
    // R6: long format bit 8 wakes, delivered
    step("R6 long tag", 0, 1, 1, 0, 1, 1, 9'h100);
    chk("R6 long woke", int'(sleeping), 0);
    // R6: short format bit 7 wakes
    step("R6 enter", 1, 1, 0, 0, 1, 0, '0);
    step("R6 short tag", 0, 1, 0, 0, 1, 1, 9'h080);
    chk("R6 short woke", int'(sleeping), 0);

    // R2: request wins over a same-cycle wake
    step("R2 enter again", 1, 1, 0, 0, 1, 0, '0);
    step("R2 req with tag", 1, 1, 0, 0, 1, 1, 9'h080);
    chk("R2 request priority", int'(sleeping), 1);

    // R1: reset while asleep
    do_reset();
    #1 chk("R1 reset clears", int'(sleeping), 0);

    // random phase
    ws = 0; lf = 0;
    for (int i = 0; i < 6000; i++) begin
      if (($urandom % 400) == 0) ws = ~ws;
      if (($urandom % 300) == 0) lf = ~lf;
      step("R3-R9 random", ($urandom % 40) == 0, ws, lf, ($urandom % 3) == 0,
           ($urandom % 25) != 0, ($urandom % 6) == 0, DW'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule